// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit Core

This block works out the operand address, or the branch target, for the addressing modes of a small 8-bit processor. The decode stage supplies a mode code and a start strobe in the same cycle. Alongside them it supplies the one or two operand bytes already taken from the instruction stream, the X and Y index registers with a selector, and the address of the instruction after the current one. The block returns a 16-bit effective address together with a one-cycle `done` strobe.

Some modes need no memory access: direct, indexed and relative. For these the result is ready one cycle after the start. The indirect modes first read a pointer from page zero through a synchronous byte-read port with a one-cycle read latency. A byte pointer costs one extra cycle. A word pointer costs two extra cycles, because it is read high byte first at `p` and then at `p+1`, and the second address wraps inside page zero. The fetched value is then used as is, indexed, or added as a signed displacement.

A controller with four states runs the sequence:
- IDLE waits for `start`. From there it goes back to IDLE with a result (non-memory mode), to ONE_BYTE (byte pointer), or to WORD_HI (word pointer).
- ONE_BYTE waits for the read data and then returns to IDLE with a result.
- WORD_HI captures the high byte, issues the second read and moves to WORD_LO.
- WORD_LO waits for the low byte and then returns to IDLE with a result.

The operand inputs are captured when the start is accepted.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (short direct) gives `{0x00, opnd_lo}`. Mode code 1 (long direct) gives `{opnd_hi, opnd_lo}`.
- R2: Mode code 2 (index only) gives the selected index register, zero-extended. `idx_sel`=0 selects `reg_x` and `idx_sel`=1 selects `reg_y`.
- R3: Mode code 3 (short indexed) gives `opnd_lo + index` as a 9-bit sum with no page wrap. The largest value is 0x01FE.
- R4: Mode code 4 (long indexed) gives `{opnd_hi, opnd_lo} + index`, taken modulo 2^16.
- R5: Mode code 5 (short indirect) issues one read at address `opnd_lo` and gives `{0x00, byte read}`. `done` follows two cycles after start.
- R6: Mode code 6 (long indirect) reads address `opnd_lo` and then `opnd_lo+1` (8-bit wrap, so 0xFF is followed by 0x00). It gives `{first byte, second byte}`, and `done` follows three cycles after start.
- R7: Mode code 7 (short indirect indexed) gives the fetched byte plus the index as a 9-bit sum. Mode code 8 (long indirect indexed) gives the fetched word plus the index, modulo 2^16.
- R8: Mode code 9 (relative) gives `next_pc` plus the sign-extended `opnd_lo`, modulo 2^16.
- R9: Mode code 10 (relative indirect) reads the displacement byte at address `opnd_lo` and gives `next_pc` plus that byte sign-extended.
- R10: Modes 0–4, 9 and 11–15 assert `done` one cycle after start. `done` lasts one cycle, and `eff_addr` holds its value until the next `done`.
- R11: A `start` during a fetch is ignored. Operand inputs that change after start do not affect the result of the pending fetch.
- R12: During and after reset, `done`=0, `mem_rd`=0 and `eff_addr`=0.
- R13: Unused mode codes 11 to 15 behave as short direct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an address computation |
| mode | input | 4 | Addressing mode code |
| idx_sel | input | 1 | Index select: 0 = X, 1 = Y |
| opnd_lo | input | 8 | Low (or only) operand byte |
| opnd_hi | input | 8 | High operand byte for long forms |
| reg_x | input | 8 | X index register |
| reg_y | input | 8 | Y index register |
| next_pc | input | 16 | Address of the following instruction |
| mem_rd | output | 1 | Page-zero read request |
| mem_addr | output | 8 | Page-zero read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle result strobe |
| eff_addr | output | 16 | Effective address |

## Verification
The bench builds the block with its default widths: an 8-bit data byte and a 16-bit address. With these widths the 9-bit carry of short indexing can be driven to its ceiling of 0x01FE, and the 16-bit wrap of long indexing and of backward relative branches can be reached. The page-zero wrap of a word pointer stored at 0xFF is also within reach. A behavioural page-zero memory logs every read address, so the order of the pointer reads, the wrap and the latency of each mode class can be observed at the ports.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        M_SDIR = 4'd0,
        M_LDIR = 4'd1,
        M_IDX0 = 4'd2,
        M_SIDX = 4'd3,
        M_LIDX = 4'd4,
        M_SIND = 4'd5,
        M_LIND = 4'd6,
        M_SINX = 4'd7,
        M_LINX = 4'd8,
        M_REL  = 4'd9,
        M_RIND = 4'd10
    } ea_mode_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_ONE_BYTE = 2'd1,
        S_WORD_HI  = 2'd2,
        S_WORD_LO  = 2'd3
    } ea_state_e;

    function automatic logic needs_byte_ptr(input ea_mode_e m);
        return (m == M_SIND) || (m == M_SINX) || (m == M_RIND);
    endfunction

    function automatic logic needs_word_ptr(input ea_mode_e m);
        return (m == M_LIND) || (m == M_LINX);
    endfunction

endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  ea_mode_e            mode,
    input  logic [DATA_W-1:0]   op_lo,
    input  logic [DATA_W-1:0]   op_hi,
    input  logic [DATA_W-1:0]   idx,
    input  logic [ADDR_W-1:0]   pc_next,
    input  logic [ADDR_W-1:0]   ptr_val,
    output logic [ADDR_W-1:0]   ea
);
    localparam int SUM_W = DATA_W + 1;
    localparam int PAD_B = ADDR_W - DATA_W;
    localparam int PAD_S = ADDR_W - SUM_W;

    logic [DATA_W-1:0] ptr_byte;
    logic [SUM_W-1:0]  sum_off;
    logic [SUM_W-1:0]  sum_ptr;
    logic [ADDR_W-1:0] idx_zx;
    logic [ADDR_W-1:0] disp_op_sx;
    logic [ADDR_W-1:0] disp_ptr_sx;

    assign ptr_byte    = ptr_val[DATA_W-1:0];
    // 9-bit sums: the carry lands in bit DATA_W instead of wrapping the page
    assign sum_off     = {1'b0, op_lo} + {1'b0, idx};
    assign sum_ptr     = {1'b0, ptr_byte} + {1'b0, idx};
    assign idx_zx      = {{PAD_B{1'b0}}, idx};
    assign disp_op_sx  = {{PAD_B{op_lo[DATA_W-1]}}, op_lo};
    assign disp_ptr_sx = {{PAD_B{ptr_byte[DATA_W-1]}}, ptr_byte};

    always_comb begin
        unique case (mode)
            M_SDIR:  ea = {{PAD_B{1'b0}}, op_lo};
            M_LDIR:  ea = {op_hi, op_lo};
            M_IDX0:  ea = idx_zx;
            M_SIDX:  ea = {{PAD_S{1'b0}}, sum_off};
            M_LIDX:  ea = {op_hi, op_lo} + idx_zx;
            M_SIND:  ea = {{PAD_B{1'b0}}, ptr_byte};
            M_LIND:  ea = ptr_val;
            M_SINX:  ea = {{PAD_S{1'b0}}, sum_ptr};
            M_LINX:  ea = ptr_val + idx_zx;
            M_REL:   ea = pc_next + disp_op_sx;
            M_RIND:  ea = pc_next + disp_ptr_sx;
            default: ea = {{PAD_B{1'b0}}, op_lo};
        endcase
    end

endmodule

// File: rtl/ea_fetch_fsm.sv
module ea_fetch_fsm
    import ea_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  ea_mode_e          mode_in,
    input  logic [DATA_W-1:0] ptr_in,
    input  logic [DATA_W-1:0] ptr_q,
    output logic              busy,
    output logic              load_res,
    output logic              cap_hi,
    output logic              word_phase,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_addr,
    output logic              done
);
    ea_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= load_res;
        end
    end

    always_comb begin
        state_d  = state_q;
        load_res = 1'b0;
        cap_hi   = 1'b0;
        mem_rd   = 1'b0;
        mem_addr = ptr_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (needs_word_ptr(mode_in)) begin
                        state_d  = S_WORD_HI;
                        mem_rd   = 1'b1;
                        mem_addr = ptr_in;
                    end else if (needs_byte_ptr(mode_in)) begin
                        state_d  = S_ONE_BYTE;
                        mem_rd   = 1'b1;
                        mem_addr = ptr_in;
                    end else begin
                        load_res = 1'b1;
                    end
                end
            end
            S_ONE_BYTE: begin
                state_d  = S_IDLE;
                load_res = 1'b1;
            end
            S_WORD_HI: begin
                state_d  = S_WORD_LO;
                cap_hi   = 1'b1;
                mem_rd   = 1'b1;
                mem_addr = ptr_q + DATA_W'(1);
            end
            S_WORD_LO: begin
                state_d  = S_IDLE;
                load_res = 1'b1;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign busy       = (state_q != S_IDLE);
    assign word_phase = (state_q == S_WORD_LO);

    assert_hi_then_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WORD_HI) |=> (state_q == S_WORD_LO));

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WORD_HI) |-> (mem_rd && mem_addr == DATA_W'($past(mem_addr) + 1'b1)));

    assert_byte_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ONE_BYTE) |=> done);

    assert_busy_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic              idx_sel,
    input  logic [DATA_W-1:0] opnd_lo,
    input  logic [DATA_W-1:0] opnd_hi,
    input  logic [DATA_W-1:0] reg_x,
    input  logic [DATA_W-1:0] reg_y,
    input  logic [ADDR_W-1:0] next_pc,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int PAD_B = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] SHORT_MAX = ADDR_W'((2 ** (DATA_W + 1)) - 2);

    ea_mode_e          mode_live, mode_q, mode_sel;
    logic [DATA_W-1:0] idx_live, idx_q, idx_use;
    logic [DATA_W-1:0] lo_q, hi_q, lo_use, hi_use, ptr_hi_q;
    logic [ADDR_W-1:0] pc_q, pc_use, ptr_val, ea_next;
    logic              busy, load_res, cap_hi, word_phase, accept;

    assign mode_live = ea_mode_e'(mode);
    assign idx_live  = idx_sel ? reg_y : reg_x;
    assign accept    = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= M_SDIR;
            idx_q    <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            pc_q     <= '0;
            ptr_hi_q <= '0;
            eff_addr <= '0;
        end else begin
            if (accept) begin
                mode_q <= mode_live;
                idx_q  <= idx_live;
                lo_q   <= opnd_lo;
                hi_q   <= opnd_hi;
                pc_q   <= next_pc;
            end
            if (cap_hi)   ptr_hi_q <= mem_rdata;
            if (load_res) eff_addr <= ea_next;
        end
    end

    // Non-memory modes resolve in the start cycle from the live inputs;
    // pointer modes resolve later from the captured copies.
    assign mode_sel = busy ? mode_q : mode_live;
    assign idx_use  = busy ? idx_q  : idx_live;
    assign lo_use   = busy ? lo_q   : opnd_lo;
    assign hi_use   = busy ? hi_q   : opnd_hi;
    assign pc_use   = busy ? pc_q   : next_pc;
    assign ptr_val  = word_phase ? {ptr_hi_q, mem_rdata} : {{PAD_B{1'b0}}, mem_rdata};

    ea_fetch_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_in    (mode_live),
        .ptr_in     (opnd_lo),
        .ptr_q      (lo_q),
        .busy       (busy),
        .load_res   (load_res),
        .cap_hi     (cap_hi),
        .word_phase (word_phase),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .done       (done)
    );

    ea_addr_calc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_calc (
        .mode    (mode_sel),
        .op_lo   (lo_use),
        .op_hi   (hi_use),
        .idx     (idx_use),
        .pc_next (pc_use),
        .ptr_val (ptr_val),
        .ea      (ea_next)
    );

    assert_direct_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !needs_byte_ptr(mode_live) && !needs_word_ptr(mode_live)) |=> done);

    assert_short_idx_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == M_SIDX || mode_q == M_SINX)) |-> (eff_addr <= SHORT_MAX));

    assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_res) |=> $stable(eff_addr));

endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic        idx_sel = 1'b0;
    logic [7:0]  opnd_lo = '0, opnd_hi = '0, reg_x = '0, reg_y = '0;
    logic [15:0] next_pc = '0;
    logic        mem_rd;
    logic [7:0]  mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        done;
    logic [15:0] eff_addr;

    logic [7:0]  pz [256];
    logic [7:0]  rd_log [8];
    int          rd_cnt = 0;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 0;

    ea_gen dut (.*);

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= pz[mem_addr];
            if (rd_cnt < 8) rd_log[rd_cnt] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [3:0] m, input logic [7:0] lo,
                                          input logic [7:0] hi, input logic [7:0] ix,
                                          input logic [15:0] pc);
        logic [7:0]  b;
        logic [15:0] w;
        b = pz[lo];
        w = {pz[lo], pz[8'(lo + 8'd1)]};
        case (m)
            4'd0:    return {8'h00, lo};
            4'd1:    return {hi, lo};
            4'd2:    return {8'h00, ix};
            4'd3:    return {8'h00, lo} + {8'h00, ix};
            4'd4:    return {hi, lo} + {8'h00, ix};
            4'd5:    return {8'h00, b};
            4'd6:    return w;
            4'd7:    return {8'h00, b} + {8'h00, ix};
            4'd8:    return w + {8'h00, ix};
            4'd9:    return pc + {{8{lo[7]}}, lo};
            4'd10:   return pc + {{8{b[7]}}, b};
            default: return {8'h00, lo};
        endcase
    endfunction

    function automatic int model_lat(input logic [3:0] m);
        if (m == 4'd5 || m == 4'd7 || m == 4'd10) return 2;
        if (m == 4'd6 || m == 4'd8) return 3;
        return 1;
    endfunction

    // One computation: start at a negedge, count negedges until done.
    task automatic run(input string req, input logic [3:0] m, input logic sel,
                       input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc);
        logic [15:0] exp;
        logic [15:0] held;
        int lat;
        exp = model(m, lo, hi, sel ? y : x, pc);
        @(negedge clk);
        mode = m; idx_sel = sel; opnd_lo = lo; opnd_hi = hi;
        reg_x = x; reg_y = y; next_pc = pc; start = 1'b1; rd_cnt = 0;
        lat = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (done && lat == 0) begin
                lat = k;
                break;
            end
        end
        chk(lat == model_lat(m), req, "latency", lat, model_lat(m));
        chk(eff_addr == exp, req, "address", eff_addr, exp);
        held = eff_addr;
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", done, 0);
        chk(eff_addr == held, "R10", "hold", eff_addr, held);
    endtask

    task automatic t_reset;
        chk(done == 1'b0, "R12", "done", done, 0);
        chk(mem_rd == 1'b0, "R12", "mem_rd", mem_rd, 0);
        chk(eff_addr == 16'h0, "R12", "eff_addr", eff_addr, 0);
    endtask

    task automatic t_direct;
        run("R1", 4'd0, 0, 8'h9A, 8'h55, 8'h11, 8'h22, 16'h4000);
        run("R1", 4'd1, 0, 8'h34, 8'h12, 8'h11, 8'h22, 16'h4000);
        run("R13", 4'd13, 1, 8'hC3, 8'h77, 8'h11, 8'h22, 16'h4000);
        run("R13", 4'd15, 0, 8'h06, 8'hFF, 8'h11, 8'h22, 16'h4000);
    endtask

    task automatic t_index;
        run("R2", 4'd2, 0, 8'h00, 8'h00, 8'h5C, 8'hE1, 16'h0);
        run("R2", 4'd2, 1, 8'h00, 8'h00, 8'h5C, 8'hE1, 16'h0);
        run("R3", 4'd3, 0, 8'hFF, 8'h00, 8'hFF, 8'h01, 16'h0);
        run("R3", 4'd3, 1, 8'h80, 8'h00, 8'h01, 8'h90, 16'h0);
        run("R4", 4'd4, 0, 8'hF0, 8'hFF, 8'h20, 8'h00, 16'h0);
        run("R4", 4'd4, 1, 8'h00, 8'h10, 8'h00, 8'h55, 16'h0);
    endtask

    task automatic t_indirect;
        pz[8'h40] = 8'hC7;
        run("R5", 4'd5, 0, 8'h40, 8'h00, 8'h33, 8'h44, 16'h0);
        chk(rd_cnt == 1 && rd_log[0] == 8'h40, "R5", "read addr", rd_log[0], 8'h40);
        pz[8'h30] = 8'hAB; pz[8'h31] = 8'hCD;
        run("R6", 4'd6, 0, 8'h30, 8'h00, 8'h00, 8'h00, 16'h0);
        chk(rd_log[0] == 8'h30 && rd_log[1] == 8'h31, "R6", "read order", rd_log[1], 8'h31);
        pz[8'hFF] = 8'h12; pz[8'h00] = 8'h34;
        run("R6", 4'd6, 1, 8'hFF, 8'h00, 8'h00, 8'h00, 16'h0);
        chk(rd_cnt == 2 && rd_log[1] == 8'h00, "R6", "page wrap", rd_log[1], 8'h00);
        pz[8'h50] = 8'hF0;
        run("R7", 4'd7, 0, 8'h50, 8'h00, 8'h20, 8'h00, 16'h0);
        pz[8'h60] = 8'hFF; pz[8'h61] = 8'hF0;
        run("R7", 4'd8, 1, 8'h60, 8'h00, 8'h00, 8'h30, 16'h0);
    endtask

    task automatic t_relative;
        run("R8", 4'd9, 0, 8'h80, 8'h00, 8'h00, 8'h00, 16'h2000);
        run("R8", 4'd9, 0, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h2000);
        run("R8", 4'd9, 0, 8'hF0, 8'h00, 8'h00, 8'h00, 16'h0005);
        pz[8'h70] = 8'h85;
        run("R9", 4'd10, 0, 8'h70, 8'h00, 8'h00, 8'h00, 16'h3000);
        pz[8'h71] = 8'h10;
        run("R9", 4'd10, 1, 8'h71, 8'h00, 8'h00, 8'h00, 16'hFFF8);
    endtask

    task automatic t_busy;
        int lat;
        int dones;
        @(negedge clk);
        mode = 4'd6; opnd_lo = 8'h30; idx_sel = 0; start = 1'b1;
        lat = 0; dones = 0;
        @(negedge clk);
        // change everything while the word fetch is running, keep start high
        mode = 4'd0; opnd_lo = 8'h70; opnd_hi = 8'h99; reg_x = 8'h01;
        for (int k = 2; k <= 4; k++) begin
            @(negedge clk);
            if (done) begin
                dones++;
                if (lat == 0) lat = k;
            end
            if (k == 3) chk(eff_addr == 16'hABCD, "R11", "fetch result", eff_addr, 16'hABCD);
        end
        start = 1'b0;
        chk(lat == 3, "R11", "latency", lat, 3);
        // a start held through a busy cycle is taken only once it is idle again
        chk(dones == 2, "R11", "done count", dones, 2);
        chk(eff_addr == 16'h0070, "R11", "restart result", eff_addr, 16'h0070);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) pz[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_index();
        t_indirect();
        t_relative();
        t_busy();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule